// File: doc/BRIEF.md
# Real-Time Clock Control and Interrupt Flag Registers

This block holds the control and status registers of a real-time clock and produces its interrupt request. Software reaches a byte-wide register space of `DEPTH` locations through two ports that share one bus: an index port that selects a location and a data port that reads or writes it. Four locations have fixed meaning. Register A is rate control, and its top bit is read-only. Register B holds the enables and mode bits. Register C holds the interrupt flags and clears itself when it is read. Register D is a constant status byte. Every other location is plain byte storage.

The periodic divider, the alarm comparator and the one-second updater are outside the block. They report events through one-cycle strobes. Register B decides whether a strobe raises flags in register C, and bit 7 of C drives the interrupt output. A synchronous soft reset puts B and C into their reset state. The power-on reset loads every default.

Top module: `rtc_ctl_regs`

## Requirements
- R1: After power-on reset, A reads 0x26, B reads 0x02, C reads 0x00, D reads 0x80, and `irq_o` is low.
- R2: A data write to A (index 0x0A) stores the value with bit 7 cleared, so A always reads bit 7 as 0.
- R3: A data write to B (index 0x0B) stores the value ANDed with `B_WR_MASK` (default 0xEF, which clears bit 4).
- R4: Data writes to C (0x0C) or D (0x0D) leave both registers unchanged. In the following cycle `wr_err_o` pulses high for exactly one cycle.
- R5: A `per_stb` pulse while B bit 6 is set ORs 0xC0 into C. While B bit 6 is clear, the pulse has no effect.
- R6: A data read of C returns its current contents and clears C at that edge. `irq_o` always equals C bit 7, so it falls in the cycle after the read.
- R7: If a flag strobe arrives in the same cycle as a read of C, the read returns the old value and the new flags remain in C afterwards.
- R8: An `alm_stb` pulse while B bit 5 is set and B bit 7 is clear ORs 0xA0 into C. While B bit 7 is set, alarm and update strobes are ignored, but periodic strobes still act.
- R9: An `upd_stb` pulse while B bit 4 is set and B bit 7 is clear ORs 0x90 into C. This path is reachable only when `B_WR_MASK` keeps bit 4.
- R10: `soft_rst` ANDs B with 0x8F and clears C, and it takes priority over writes and strobes in the same cycle. A and D are unaffected.
- R11: The index port is write-only. It latches the low log2(`DEPTH`) bits of the write data, so index 0x8B selects B. A read of the index port returns 0x00.
- R12: Locations other than 0x0A to 0x0D store and return whatever byte was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; loads every default |
| soft_rst | input | 1 | Synchronous soft reset of B and C |
| bus_sel | input | 1 | Port select: 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_rd | input | 1 | Read strobe for the selected port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected port and index |
| per_stb | input | 1 | Periodic event strobe |
| alm_stb | input | 1 | Alarm match strobe |
| upd_stb | input | 1 | Update-ended strobe |
| irq_o | output | 1 | Interrupt request, equal to C bit 7 |
| wr_err_o | output | 1 | One-cycle pulse after a data write to C or D |

## Verification
The flag logic is driven in four ways. Single strobes with the matching enable set or clear show that each enable gates only its own source. Strobes with B bit 7 set show that this bit suppresses alarm and update strobes but not periodic ones. A read of C in the same cycle as a strobe shows whether the clear wins over a new flag. Writes of all-ones to each control register expose the per-register masks, and a second instance with an open B mask is the only way to reach the update-ended flag. Randomly mixed index writes, data accesses, strobes and soft resets are then compared against a reference model in the bench, which exercises the ordering between clearing, setting and resetting.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
   localparam int ADR_CTL_A = 'h0A;
   localparam int ADR_CTL_B = 'h0B;
   localparam int ADR_FLG_C = 'h0C;
   localparam int ADR_STS_D = 'h0D;

   localparam logic [7:0] A_POR_VAL  = 8'h26;
   localparam logic [7:0] B_POR_VAL  = 8'h02;
   localparam logic [7:0] D_CONST    = 8'h80;
   localparam logic [7:0] A_WR_KEEP  = 8'h7F;
   localparam logic [7:0] B_RST_KEEP = 8'h8F;

   localparam logic [7:0] FLG_PER = 8'hC0;
   localparam logic [7:0] FLG_ALM = 8'hA0;
   localparam logic [7:0] FLG_UPD = 8'h90;

   // positions inside the upper nibble of B
   localparam int BH_HOLD = 3;
   localparam int BH_PER  = 2;
   localparam int BH_ALM  = 1;
   localparam int BH_UPD  = 0;

   typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} bus_port_e;
endpackage

// File: rtl/rtc_ctl_ab.sv
module rtc_ctl_ab
   import rtc_regs_pkg::*;
#(
   parameter logic [7:0] B_WR_MASK = 8'hEF
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       soft_rst,
   input  logic       wr_a,
   input  logic       wr_b,
   input  logic [7:0] wdata,
   output logic [7:0] a_q,
   output logic [7:0] b_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         a_q <= A_POR_VAL;
         b_q <= B_POR_VAL;
      end else begin
         if (wr_a) a_q <= wdata & A_WR_KEEP;
         if (soft_rst)  b_q <= b_q & B_RST_KEEP;
         else if (wr_b) b_q <= wdata & B_WR_MASK;
      end
   end

   AST_A_TOP_LOW: assert property (@(posedge clk) disable iff (!por_n)
      a_q[7] == 1'b0); // R2
   AST_B_MASKED: assert property (@(posedge clk) disable iff (!por_n)
      (wr_b && !soft_rst) |=> ((b_q & ~B_WR_MASK) == 8'h00)); // R3
   AST_B_SOFT_RST: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> (b_q[6:4] == 3'b000)); // R10
endmodule

// File: rtl/rtc_flag_c.sv
module rtc_flag_c
   import rtc_regs_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       soft_rst,
   input  logic       rd_clr,
   input  logic       per_stb,
   input  logic       alm_stb,
   input  logic       upd_stb,
   input  logic [3:0] b_hi,
   output logic [7:0] c_q,
   output logic       irq_o
);
   logic [7:0] set_v;

   always_comb begin
      set_v = 8'h00;
      if (per_stb && b_hi[BH_PER]) set_v = set_v | FLG_PER;
      if (!b_hi[BH_HOLD]) begin
         if (alm_stb && b_hi[BH_ALM]) set_v = set_v | FLG_ALM;
         if (upd_stb && b_hi[BH_UPD]) set_v = set_v | FLG_UPD;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        c_q <= 8'h00;
      else if (soft_rst) c_q <= 8'h00;
      else if (rd_clr)   c_q <= set_v;
      else               c_q <= c_q | set_v;
   end

   assign irq_o = c_q[7];

   AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!por_n)
      (rd_clr && !per_stb && !alm_stb && !upd_stb) |=> !irq_o); // R6
   AST_FLAG_SURVIVES: assert property (@(posedge clk) disable iff (!por_n)
      (rd_clr && per_stb && b_hi[BH_PER] && !soft_rst) |=> (c_q[7:6] == 2'b11)); // R7
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      (!rd_clr && !soft_rst) |=> ((c_q & $past(c_q)) == $past(c_q))); // R5
   AST_C_SOFT_RST: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> (c_q == 8'h00)); // R10
endmodule

// File: rtl/rtc_ram_bank.sv
module rtc_ram_bank #(
   parameter int DEPTH = 128,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
   import rtc_regs_pkg::*;
#(
   parameter int         DEPTH     = 128,
   parameter logic [7:0] B_WR_MASK = 8'hEF
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       soft_rst,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       per_stb,
   input  logic       alm_stb,
   input  logic       upd_stb,
   output logic       irq_o,
   output logic       wr_err_o
);
   localparam int AW = $clog2(DEPTH);

   if (!(DEPTH == 64 || DEPTH == 128)) begin : g_bad_depth
      $error("rtc_ctl_regs: DEPTH must be 64 or 128");
   end

   logic [AW-1:0] idx_q;
   logic [7:0]    a_q, b_q, c_q, ram_rd;
   logic          is_data, wr_data, rd_data;
   logic          hit_a, hit_b, hit_c, hit_d, hit_ctl;

   assign is_data = (bus_sel == PORT_DATA);
   assign wr_data = bus_wr && is_data;
   assign rd_data = bus_rd && is_data;

   assign hit_a   = (idx_q == AW'(ADR_CTL_A));
   assign hit_b   = (idx_q == AW'(ADR_CTL_B));
   assign hit_c   = (idx_q == AW'(ADR_FLG_C));
   assign hit_d   = (idx_q == AW'(ADR_STS_D));
   assign hit_ctl = hit_a || hit_b || hit_c || hit_d;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         idx_q    <= '0;
         wr_err_o <= 1'b0;
      end else begin
         if (bus_wr && !is_data) idx_q <= bus_wdata[AW-1:0];
         wr_err_o <= wr_data && (hit_c || hit_d);
      end
   end

   rtc_ctl_ab #(.B_WR_MASK(B_WR_MASK)) u_ctl_ab (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
      .wr_a(wr_data && hit_a), .wr_b(wr_data && hit_b),
      .wdata(bus_wdata), .a_q(a_q), .b_q(b_q)
   );

   rtc_flag_c u_flag_c (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
      .rd_clr(rd_data && hit_c), .per_stb(per_stb), .alm_stb(alm_stb),
      .upd_stb(upd_stb), .b_hi(b_q[7:4]), .c_q(c_q), .irq_o(irq_o)
   );

   rtc_ram_bank #(.DEPTH(DEPTH)) u_ram (
      .clk(clk), .we(wr_data && !hit_ctl), .addr(idx_q),
      .wdata(bus_wdata), .rdata(ram_rd)
   );

   always_comb begin
      if (!is_data)   bus_rdata = 8'h00;
      else if (hit_a) bus_rdata = a_q;
      else if (hit_b) bus_rdata = b_q;
      else if (hit_c) bus_rdata = c_q;
      else if (hit_d) bus_rdata = D_CONST;
      else            bus_rdata = ram_rd;
   end

   AST_RO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!por_n)
      (wr_data && (hit_c || hit_d)) |=> wr_err_o); // R4
   AST_C_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
      (wr_data && hit_c && !rd_data && !per_stb && !alm_stb && !upd_stb && !soft_rst)
      |=> $stable(c_q)); // R4
   AST_IDX_PORT_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && !is_data) |-> (bus_rdata == 8'h00)); // R11
endmodule

// File: tb/rtc_ctl_regs_tb.sv
module rtc_ctl_regs_tb;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       soft_rst = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic       per_stb = 1'b0, alm_stb = 1'b0, upd_stb = 1'b0;
   logic [7:0] bus_rdata, rdata2;
   logic       irq_o, wr_err_o, irq2, err2;

   int n_checks = 0, n_errors = 0;
   bit done = 1'b0;

   logic [7:0] m_a = 8'h26, m_b = 8'h02, m_c = 8'h00;
   logic [6:0] m_idx = 7'h00;
   logic       m_err = 1'b0;
   logic [7:0] m_ram [128];
   bit         m_ok  [128];

   logic [7:0] s_rd, s_rd2;
   logic       s_irq, s_err, s_irq2;

   always #4 clk = ~clk;

   rtc_ctl_regs u_dut (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .per_stb(per_stb), .alm_stb(alm_stb), .upd_stb(upd_stb),
      .irq_o(irq_o), .wr_err_o(wr_err_o)
   );

   rtc_ctl_regs #(.B_WR_MASK(8'hFF)) u_open (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
      .per_stb(per_stb), .alm_stb(alm_stb), .upd_stb(upd_stb),
      .irq_o(irq2), .wr_err_o(err2)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic string tag_of(input logic sel, input logic [6:0] idx);
      if (!sel) return "R11";
      case (idx)
         7'h0A: return "R2";
         7'h0B: return "R3";
         7'h0C: return "R6";
         7'h0D: return "R4";
         default: return "R12";
      endcase
   endfunction

   function automatic logic [7:0] model_rd(input logic sel);
      if (!sel) return 8'h00;
      case (m_idx)
         7'h0A: return m_a;
         7'h0B: return m_b;
         7'h0C: return m_c;
         7'h0D: return 8'h80;
         default: return m_ram[m_idx];
      endcase
   endfunction

   function automatic logic [7:0] flag_set(input logic per, input logic alm, input logic upd);
      logic [7:0] s = 8'h00;
      if (per && m_b[6]) s = s | 8'hC0;
      if (!m_b[7] && alm && m_b[5]) s = s | 8'hA0;
      if (!m_b[7] && upd && m_b[4]) s = s | 8'h90;
      return s;
   endfunction

   task automatic cyc(input logic sel, input logic wr, input logic rd, input logic [7:0] wd,
                      input logic per, input logic alm, input logic upd, input logic srst);
      logic [7:0] fs;
      bit ctl;
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
      per_stb = per; alm_stb = alm; upd_stb = upd; soft_rst = srst;
      #1;
      s_rd = bus_rdata; s_rd2 = rdata2; s_irq = irq_o; s_err = wr_err_o; s_irq2 = irq2;
      check("R6", {7'b0, s_irq}, {7'b0, m_c[7]});
      check("R4", {7'b0, s_err}, {7'b0, m_err});
      if (rd && (!sel || m_idx < 7'h0A || m_idx > 7'h0D ? (!sel || m_ok[m_idx]) : 1'b1))
         check(tag_of(sel, m_idx), s_rd, model_rd(sel));
      fs  = flag_set(per, alm, upd);
      ctl = (m_idx >= 7'h0A && m_idx <= 7'h0D);
      m_err = wr && sel && (m_idx == 7'h0C || m_idx == 7'h0D);
      if (srst) m_c = 8'h00;
      else if (rd && sel && m_idx == 7'h0C) m_c = fs;
      else m_c = m_c | fs;
      if (wr && sel && m_idx == 7'h0A) m_a = wd & 8'h7F;
      if (srst) m_b = m_b & 8'h8F;
      else if (wr && sel && m_idx == 7'h0B) m_b = wd & 8'hEF;
      if (wr && sel && !ctl) begin m_ram[m_idx] = wd; m_ok[m_idx] = 1'b1; end
      if (wr && !sel) m_idx = wd[6:0];
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0; per_stb = 1'b0; alm_stb = 1'b0;
      upd_stb = 1'b0; soft_rst = 1'b0;
   endtask

   task automatic wr_idx(input logic [7:0] a); cyc(1'b0, 1'b1, 1'b0, a, 0, 0, 0, 0); endtask
   task automatic wr_dat(input logic [7:0] v); cyc(1'b1, 1'b1, 1'b0, v, 0, 0, 0, 0); endtask
   task automatic rd_dat();                    cyc(1'b1, 1'b0, 1'b1, 8'h00, 0, 0, 0, 0); endtask
   task automatic stb(input logic p, input logic a, input logic u);
      cyc(1'b1, 1'b0, 1'b0, 8'h00, p, a, u, 0);
   endtask
   task automatic set_reg(input logic [7:0] a, input logic [7:0] v);
      wr_idx(a); wr_dat(v);
   endtask
   task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] v);
      wr_idx(a); rd_dat(); check(req, s_rd, v);
   endtask

   initial begin
      void'($urandom(32'h5EED_0017));
      for (int i = 0; i < 128; i++) m_ok[i] = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;

      // R1: defaults
      expect_reg("R1", 8'h0A, 8'h26);
      expect_reg("R1", 8'h0B, 8'h02);
      expect_reg("R1", 8'h0C, 8'h00);
      check("R1", {7'b0, s_irq}, 8'h00);
      expect_reg("R1", 8'h0D, 8'h80);

      // R9 / R3: update-ended path only opens with a full B mask
      set_reg(8'h0B, 8'h10);
      rd_dat();
      check("R3", s_rd, 8'h00);
      check("R9", s_rd2, 8'h10);
      stb(0, 0, 1);
      wr_idx(8'h0C);
      check("R9", {7'b0, s_irq2}, 8'h01);
      check("R9", {7'b0, s_irq}, 8'h00);
      rd_dat();
      check("R9", s_rd2, 8'h90);
      check("R9", s_rd, 8'h00);
      set_reg(8'h0B, 8'h02);

      // R2
      set_reg(8'h0A, 8'hFF);
      rd_dat(); check("R2", s_rd, 8'h7F);
      set_reg(8'h0A, 8'h26);

      // R3
      set_reg(8'h0B, 8'hFF);
      rd_dat(); check("R3", s_rd, 8'hEF);
      set_reg(8'h0B, 8'h02);

      // R4: writes to C and D ignored, error pulse
      set_reg(8'h0C, 8'hFF);
      rd_dat(); check("R4", s_rd, 8'h00); check("R4", {7'b0, s_err}, 8'h01);
      rd_dat(); check("R4", {7'b0, s_err}, 8'h00);
      set_reg(8'h0D, 8'h00);
      rd_dat(); check("R4", s_rd, 8'h80); check("R4", {7'b0, s_err}, 8'h01);

      // R5 / R6: periodic flag, read clears and drops irq
      stb(1, 0, 0);
      expect_reg("R5", 8'h0C, 8'h00);
      set_reg(8'h0B, 8'h40);
      stb(1, 0, 0);
      wr_idx(8'h0C);
      check("R6", {7'b0, s_irq}, 8'h01);
      rd_dat(); check("R5", s_rd, 8'hC0);
      stb(0, 0, 0);
      check("R6", {7'b0, s_irq}, 8'h00);
      rd_dat(); check("R6", s_rd, 8'h00);

      // R7: strobe in the same cycle as the clearing read
      cyc(1'b1, 1'b0, 1'b1, 8'h00, 1, 0, 0, 0);
      check("R7", s_rd, 8'h00);
      rd_dat(); check("R7", s_rd, 8'hC0);
      stb(1, 0, 0);
      cyc(1'b1, 1'b0, 1'b1, 8'h00, 1, 0, 0, 0);
      check("R7", s_rd, 8'hC0);
      rd_dat(); check("R7", s_rd, 8'hC0);

      // R8: alarm, and hold bit gating
      set_reg(8'h0B, 8'h20);
      stb(0, 1, 0);
      expect_reg("R8", 8'h0C, 8'hA0);
      set_reg(8'h0B, 8'hE0);
      stb(1, 1, 0);
      expect_reg("R8", 8'h0C, 8'hC0);

      // R10: soft reset
      set_reg(8'h0B, 8'hFF);
      stb(1, 0, 0);
      cyc(1'b1, 1'b0, 1'b0, 8'h00, 0, 0, 0, 1);
      expect_reg("R10", 8'h0B, 8'h8F);
      expect_reg("R10", 8'h0C, 8'h00);
      expect_reg("R10", 8'h0A, 8'h26);
      expect_reg("R10", 8'h0D, 8'h80);
      set_reg(8'h0B, 8'h40);
      cyc(1'b1, 1'b1, 1'b0, 8'h00, 1, 0, 0, 1);
      expect_reg("R10", 8'h0C, 8'h00);

      // R11: index truncation and write-only index port
      set_reg(8'h0B, 8'h02);
      wr_idx(8'h8B);
      rd_dat(); check("R11", s_rd, 8'h02);
      cyc(1'b0, 1'b0, 1'b1, 8'h00, 0, 0, 0, 0);
      check("R11", s_rd, 8'h00);

      // R12: plain storage
      set_reg(8'h40, 8'h5A);
      set_reg(8'h0E, 8'hA5);
      set_reg(8'h7F, 8'h3C);
      expect_reg("R12", 8'h40, 8'h5A);
      expect_reg("R12", 8'h0E, 8'hA5);
      expect_reg("R12", 8'h7F, 8'h3C);

      // random mix against the model
      for (int k = 0; k < 800; k++) begin
         int op;
         logic [7:0] v;
         op = $urandom % 4;
         v  = 8'($urandom);
         if (op == 0) begin
            if ($urandom % 2 == 0) v = 8'h0A + 8'($urandom % 4);
            cyc(1'b0, 1'b1, 1'b0, v, 0, 0, 0, 0);
         end else begin
            cyc(1'b1, op == 1, op == 2, v,
                ($urandom % 5 == 0), ($urandom % 5 == 0), ($urandom % 5 == 0),
                ($urandom % 60 == 0));
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule